// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives one pulse-width-modulated output from a prescaled 8-bit timer. Two fine-count bits below the timer extend it into a 10-bit time base. The timer counts up to a programmable 8-bit period limit, and one timer step spans four fine steps. The output goes high when a period starts. It goes low when the 10-bit time base reaches the latched duty value.

Software writes a duty value in two parts: eight high bits in a duty register and two low bits in a field of the control register. That value sits in a master copy. It reaches the comparator only through a slave copy, which is loaded when a period rolls over. A duty change made in the middle of a period therefore never produces a glitched pulse.

The control register also selects the input prescaler and holds the mode field. Any mode other than PWM holds the counters at zero and drives the output low.

Top module: `pwm10_gen`

## Requirements
- R1: After reset, the output is low, and it stays low until the mode field selects PWM.
- R2: The control byte uses bits [1:0] for the prescaler: 00 divides by 1, 01 by 4, and 10 or 11 by 16. The PWM period is (PERIOD + 1) × 4 × prescale input clocks.
- R3: A rollover occurs on the fine step after the time base reaches {PERIOD, 2'b11}. At rollover the time base returns to zero and the output goes high, except for the case in R6.
- R4: The duty value D is {duty register[7:0], control bits [3:2]}. The output stays high for D × prescale input clocks from the start of each period.
- R5: The duty value is copied into the slave register only at rollover. A duty write in mid-period first changes the waveform in the next period.
- R6: If the duty value loaded at rollover is zero, the output stays low for the whole period.
- R7: If D ≥ 4 × (PERIOD + 1), the output stays high for the whole period.
- R8: The mode field is control bits [5:4], and only 11 selects PWM. When the control register holds any other mode, the output is driven low on the next clock, and the prescaler and time base are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| per_we | input | 1 | Write strobe for the period register |
| per_d | input | 8 | Period register write data |
| dhi_we | input | 1 | Write strobe for the high 8 bits of the duty value |
| dhi_d | input | 8 | Duty high-part write data |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_d | input | 8 | Control write data: prescale [1:0], duty low [3:2], mode [5:4] |
| pwm_o | output | 1 | PWM output |

## Verification
A miscounted prescaler or fine count shows at the pin as a wrong period length. It appears within the first full period after the setting is applied. An off-by-one in the compare against the slave register changes the high time by exactly one prescaled step, and this is visible in every period. A slave register that loads at the wrong moment shows up in the period in which a mid-period duty write is made: that pulse takes the new width instead of the old one. A faulty mode decode leaves the output toggling, or fails to drop it, within two clocks of the control write.

// File: rtl/pwm10_pkg.sv
// Package: shared widths, control-byte field positions and prescaler decode
// for the 10-bit PWM generator. Assumes an 8-bit control byte.
package pwm10_pkg;
    localparam int CTL_W      = 8;
    localparam int PS_LSB     = 0;
    localparam int DLO_LSB    = 2;
    localparam int MODE_LSB   = 4;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RSV1 = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_PWM  = 2'b11
    } pwm_mode_e;

    // Terminal count of the prescaler for a select code (divide minus one)
    function automatic logic [3:0] ps_limit(input logic [1:0] sel);
        case (sel)
            2'b00:   ps_limit = 4'd0;
            2'b01:   ps_limit = 4'd3;
            default: ps_limit = 4'd15;
        endcase
    endfunction
endpackage

// File: rtl/pwm10_prescaler.sv
// Module: input-clock prescaler. Emits a one-clock tick every 1, 4 or 16
// clocks according to the select code. Assumes the select may change at any
// time; the counter is held at zero while the block is disabled.
module pwm10_prescaler
    import pwm10_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    assign lim  = CNT_W'(ps_limit(sel));
    assign tick = en && (cnt_q >= lim);

    // Count input clocks up to the selected terminal value, then restart
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt_q <= '0;
        else if (cnt_q >= lim)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: with a divider above one, ticks never come on consecutive clocks
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 2'b00) |=> (!tick || sel == 2'b00));

    // R8: disabled prescaler produces no ticks
    p_no_tick_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);
endmodule

// File: rtl/pwm10_timebase.sv
// Module: 10-bit time base built from a period timer and fine bits below it.
// The fine bits advance on each prescaler tick and carry into the timer.
// A rollover happens on the tick after {timer, fine} reaches {period, all ones}.
// Assumes the period may be lowered below the running timer; the timer then
// wraps through its full range before matching again.
module pwm10_timebase #(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    localparam int TB_W  = TMR_W + FINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [TMR_W-1:0] period,
    output logic [TB_W-1:0]  tb_q,
    output logic [TB_W-1:0]  tb_nxt,
    output logic             wrap
);
    logic [TMR_W-1:0]  tmr;
    logic [FINE_W-1:0] fine;

    assign tmr  = tb_q[TB_W-1:FINE_W];
    assign fine = tb_q[FINE_W-1:0];
    assign wrap = tick && (&fine) && (tmr == period);

    // Next time-base value: clear at rollover, step on tick, else hold
    always_comb begin
        if (wrap)
            tb_nxt = '0;
        else if (tick)
            tb_nxt = tb_q + 1'b1;
        else
            tb_nxt = tb_q;
    end

    // Time-base register, held at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            tb_q <= '0;
        else
            tb_q <= tb_nxt;
    end

    // R3: rollover returns the time base to zero
    p_wrap_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap) |=> (tb_q == '0));

    // R2: the time base moves only on a prescaler tick
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> (!en || $stable(tb_q)));

    // R8: disabled time base sits at zero
    p_tb_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tb_q == '0));
endmodule

// File: rtl/pwm10_regs.sv
// Module: register file for period, control and master duty, plus the slave
// duty register loaded at each rollover. Assumes single-clock write strobes;
// a write in the rollover cycle lands in the master after the slave load.
module pwm10_regs
    import pwm10_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    localparam int TB_W  = TMR_W + FINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_we,
    input  logic [TMR_W-1:0] per_d,
    input  logic             dhi_we,
    input  logic [TMR_W-1:0] dhi_d,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_d,
    input  logic             wrap,
    output logic [TMR_W-1:0] period,
    output logic [1:0]       ps_sel,
    output logic             en,
    output logic [TB_W-1:0]  master,
    output logic [TB_W-1:0]  slave
);
    logic [TMR_W-1:0] dhi_q;
    logic [CTL_W-1:0] ctl_q;
    pwm_mode_e        mode;

    assign mode   = pwm_mode_e'(ctl_q[MODE_LSB +: 2]);
    assign en     = (mode == MODE_PWM);
    assign ps_sel = ctl_q[PS_LSB +: 2];
    assign master = {dhi_q, ctl_q[DLO_LSB +: FINE_W]};

    // Software-visible registers: period, duty high part, control byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            dhi_q  <= '0;
            ctl_q  <= '0;
        end else begin
            if (per_we) period <= per_d;
            if (dhi_we) dhi_q  <= dhi_d;
            if (ctl_we) ctl_q  <= ctl_d;
        end
    end

    // Slave duty copy, refreshed only at rollover
    always_ff @(posedge clk) begin
        if (!rst_n)
            slave <= '0;
        else if (wrap)
            slave <= master;
    end

    // R5: the slave copy only changes at rollover
    p_slave_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(slave));

    // R5: at rollover the slave takes the master value
    p_slave_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (slave == $past(master)));
endmodule

// File: rtl/pwm10_outlatch.sv
// Module: PWM output latch. Set at rollover unless the incoming duty is zero,
// cleared when the next time-base value equals the slave duty. Assumes the
// slave duty is stable between rollovers; a duty beyond the period never clears.
module pwm10_outlatch #(
    parameter int TB_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            wrap,
    input  logic            tick,
    input  logic [TB_W-1:0] tb_nxt,
    input  logic [TB_W-1:0] master,
    input  logic [TB_W-1:0] slave,
    output logic            pwm_o
);
    logic dc_match;

    assign dc_match = tick && (tb_nxt == slave);

    // Output latch: force low when off, set at rollover, clear on duty match
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            pwm_o <= 1'b0;
        else if (wrap)
            pwm_o <= (master != '0);
        else if (dc_match)
            pwm_o <= 1'b0;
    end

    // R6: zero duty at rollover keeps the output low
    p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap && master == '0) |=> !pwm_o);

    // R3: a non-zero duty at rollover drives the output high
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap && master != '0) |=> pwm_o);

    // R8: mode other than PWM forces the output low
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_o);

    // R4: the output never rises except at rollover
    p_rise_only_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_o && !wrap) |=> !pwm_o);
endmodule

// File: rtl/pwm10_gen.sv
// Module: top of the double-buffered 10-bit PWM generator. Connects the
// register file, prescaler, time base and output latch. Assumes all writes
// are synchronous single-clock strobes in the clk domain.
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    parameter int PS_W   = 4,
    localparam int TB_W  = TMR_W + FINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_we,
    input  logic [TMR_W-1:0] per_d,
    input  logic             dhi_we,
    input  logic [TMR_W-1:0] dhi_d,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_d,
    output logic             pwm_o
);
    logic [TMR_W-1:0] period;
    logic [1:0]       ps_sel;
    logic             en;
    logic [TB_W-1:0]  master;
    logic [TB_W-1:0]  slave;
    logic             tick;
    logic [TB_W-1:0]  tb_q;
    logic [TB_W-1:0]  tb_nxt;
    logic             wrap;

    pwm10_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .per_we (per_we),
        .per_d  (per_d),
        .dhi_we (dhi_we),
        .dhi_d  (dhi_d),
        .ctl_we (ctl_we),
        .ctl_d  (ctl_d),
        .wrap   (wrap),
        .period (period),
        .ps_sel (ps_sel),
        .en     (en),
        .master (master),
        .slave  (slave)
    );

    pwm10_prescaler #(.CNT_W(PS_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .sel   (ps_sel),
        .tick  (tick)
    );

    pwm10_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .tick   (tick),
        .period (period),
        .tb_q   (tb_q),
        .tb_nxt (tb_nxt),
        .wrap   (wrap)
    );

    pwm10_outlatch #(.TB_W(TB_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .wrap   (wrap),
        .tick   (tick),
        .tb_nxt (tb_nxt),
        .master (master),
        .slave  (slave),
        .pwm_o  (pwm_o)
    );

    // R1: right after reset the output is low
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> !pwm_o);
endmodule

// File: tb/test_pwm10_gen.sv
module test_pwm10_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       per_we = 1'b0;
    logic [7:0] per_d = '0;
    logic       dhi_we = 1'b0;
    logic [7:0] dhi_d = '0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_d = '0;
    logic       pwm_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    pwm10_gen i_pwm10_gen (
        .clk(clk), .rst_n(rst_n),
        .per_we(per_we), .per_d(per_d),
        .dhi_we(dhi_we), .dhi_d(dhi_d),
        .ctl_we(ctl_we), .ctl_d(ctl_d),
        .pwm_o(pwm_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic wr_per(input logic [7:0] v);
        @(negedge clk); per_d = v; per_we = 1'b1;
        @(negedge clk); per_we = 1'b0;
    endtask

    task automatic wr_dhi(input logic [7:0] v);
        @(negedge clk); dhi_d = v; dhi_we = 1'b1;
        @(negedge clk); dhi_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_d = v; ctl_we = 1'b1;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    // Returns at the first negedge where the output is seen high after low
    task automatic wait_rise();
        do @(negedge clk); while (pwm_o !== 1'b0);
        do @(negedge clk); while (pwm_o !== 1'b1);
    endtask

    // From a rise: count high clocks, then clocks to the next rise
    task automatic measure_from_rise(output int hi, output int per);
        hi = 0;
        per = 0;
        while (pwm_o === 1'b1) begin @(negedge clk); hi++; per++; end
        while (pwm_o === 1'b0) begin @(negedge clk); per++; end
    endtask

    task automatic run_wave(input string req, input logic [7:0] pr,
                            input logic [7:0] hi8, input logic [7:0] ctl,
                            input int exp_hi, input int exp_per);
        int hi, per;
        wr_per(pr);
        wr_dhi(hi8);
        wr_ctl(ctl);
        wait_rise();
        wait_rise();
        measure_from_rise(hi, per);
        check({req, " high"}, hi, exp_hi);
        check({req, " period"}, per, exp_per);
    endtask

    // R1: output low after reset with nothing configured
    task automatic t_reset();
        int highs = 0;
        check("R1 after reset", int'(pwm_o), 0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pwm_o) highs++;
        end
        check("R1 idle stays low", highs, 0);
    endtask

    // R6: zero duty keeps the output low over whole periods
    task automatic t_zero();
        int highs = 0;
        wr_dhi(8'd0);
        wr_ctl(8'h30);
        for (int i = 0; i < 80; i++) @(negedge clk);
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (pwm_o) highs++;
        end
        check("R6 zero duty high clocks", highs, 0);
    endtask

    // R7: duty beyond the period keeps the output high
    task automatic t_full();
        int lows = 0;
        wr_per(8'd9);
        wr_dhi(8'd15);
        wr_ctl(8'h3C);
        wait_rise();
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (!pwm_o) lows++;
        end
        check("R7 full duty low clocks", lows, 0);
    endtask

    // R5: mid-period write only affects the next period
    task automatic t_midwrite();
        int hi = 0;
        int hi2 = 0;
        wr_per(8'd9);
        wr_dhi(8'd2);
        wr_ctl(8'h38);
        wait_rise();
        wait_rise();
        while (pwm_o === 1'b1) begin
            @(negedge clk);
            hi++;
            if (hi == 3) begin dhi_d = 8'd7; dhi_we = 1'b1; end
            else dhi_we = 1'b0;
        end
        dhi_we = 1'b0;
        check("R5 current period keeps old duty", hi, 10);
        while (pwm_o === 1'b0) @(negedge clk);
        while (pwm_o === 1'b1) begin @(negedge clk); hi2++; end
        check("R5 next period uses new duty", hi2, 30);
    endtask

    // R8: leaving PWM mode drops the output and keeps it low
    task automatic t_off();
        int highs = 0;
        wr_per(8'd9);
        wr_dhi(8'd15);
        wr_ctl(8'h3C);
        wait_rise();
        check("R8 high before disable", int'(pwm_o), 1);
        wr_ctl(8'h1C);
        @(negedge clk);
        check("R8 low after disable", int'(pwm_o), 0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pwm_o) highs++;
        end
        check("R8 stays low while off", highs, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        // R2 R3 R4: divide by 1, D = 4*4+1 = 17, period (9+1)*4 = 40
        run_wave("R4 ps1", 8'd9, 8'd4, 8'h34, 17, 40);
        // R2 R4: divide by 4, D = 7, period (4+1)*4*4 = 80
        run_wave("R2 ps4", 8'd4, 8'd1, 8'h3D, 28, 80);
        // R2 R3: divide by 16, D = 5, period (2+1)*4*16 = 192
        run_wave("R3 ps16", 8'd2, 8'd1, 8'h36, 80, 192);
        t_zero();
        t_full();
        t_midwrite();
        t_off();
        finish_run();
    end
endmodule